// File: doc/BRIEF.md
# RNG Power-Up Self-Test Controller

This block sequences the start-up check of a random number generator's post-processing path. Straight after reset it switches the generator's bit input away from the live entropy source to a 32-bit LFSR with a fixed seed. It collects the first four 128-bit words the generator produces and folds them into a CRC-32. It then compares that checksum with a constant given at build time. A match proves that the health-test and conditioning logic downstream handled a known stimulus correctly.

On a match the controller starts phase two. It pulses a reset into the downstream conditioner, generator and capture buffer and hands the bit input back to the entropy source. It then waits for the online health test to report enough entropy before it raises the ready flag. A checksum mismatch, or a wait that runs past a programmable cycle limit in either phase, latches a fail flag. The fail flag holds ready low until the next reset. The generator has no scan or test port, so this sequence is its only production check.

Top module: `rng_selftest_ctrl`

## Requirements
- R1: While rst_n is low, src_sel, dn_rst, p1_pass, st_fail and rng_ready are all 0. Phase one begins on the first clock edge after reset is released.
- R2: During phase one, src_sel is 1 and lfsr_bit is bit 31 of a 32-bit shift register. The register is loaded with LFSR_SEED at reset and again at the start of phase one. On each phase-one clock it shifts left and takes in, at bit 0, the XOR of bits 31, 21, 1 and 0.
- R3: In phase one, the first four words presented with gen_valid are kept in arrival order as r1, r2, r3, r4.
- R4: The checksum starts at 0xFFFFFFFF and uses polynomial 0x04C11DB7, unreflected, with no final XOR. Each bit is folded in as follows: feedback = crc[31] XOR bit, crc shifts left one place, and if feedback is 1 the polynomial is XORed in. The 512 bits go MSB first, r1 first. If the result equals EXP_CRC, p1_pass goes to 1.
- R5: On a checksum mismatch, st_fail goes to 1, and dn_rst and p1_pass stay 0.
- R6: After a match, dn_rst is 1 for exactly one cycle, and src_sel is 0 from then on.
- R7: After the dn_rst pulse, ht_ok being high at a clock edge raises rng_ready. rng_ready then stays 1 until reset, whatever gen_valid and ht_ok do.
- R8: In phase two, count the cycle with dn_rst high as cycle 0. If ht_ok stays low, st_fail is 0 through cycle wait_limit and 1 from cycle wait_limit+1.
- R9: If four words do not arrive within wait_limit cycles of phase one, st_fail goes to 1 and src_sel returns to 0.
- R10: Once st_fail is 1 it stays 1 until reset, and rng_ready stays 0 even with ht_ok high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_limit | input | CW | Cycle limit for each waiting phase |
| gen_valid | input | 1 | Generator output word valid |
| gen_word | input | WW | Generator output word |
| ht_ok | input | 1 | Health test reports sufficient entropy |
| src_sel | output | 1 | 1: generator bit input takes lfsr_bit; 0: entropy source |
| lfsr_bit | output | 1 | Known test bit stream |
| dn_rst | output | 1 | One-cycle reset for conditioner, generator and buffer |
| p1_pass | output | 1 | Phase-one checksum matched |
| st_fail | output | 1 | Sticky self-test failure |
| rng_ready | output | 1 | Generator released for use |

## Verification
The checksum path is tried with three inputs. The first is the four known words in their right order, which must pass. The second is the same words with the first two swapped, which shows that the order of the words matters. The third is the right order with a single bit flipped, which shows that the checksum detects single-bit faults. Phase two is run once with the health test reporting and once with it silent. The silent run places the timeout on its exact cycle. A run with no generator words at all exercises the phase-one timeout. In every run the LFSR stream is compared bit for bit against a model started from the seed. This confirms that the seed is reloaded after each reset.

// File: rtl/rng_selftest_pkg.sv
package rng_selftest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DIGEST,
        ST_COMPARE,
        ST_FLUSH,
        ST_HTWAIT,
        ST_READY,
        ST_FAIL
    } st_e;

    function automatic logic [31:0] crc_fold_bit(logic [31:0] c, logic b, logic [31:0] poly);
        logic fb;
        fb = c[31] ^ b;
        return fb ? ({c[30:0], 1'b0} ^ poly) : {c[30:0], 1'b0};
    endfunction

endpackage

// File: rtl/rng_st_lfsr.sv
module rng_st_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = 32'h1ACE_B00C,
    parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic bit_o
);
    logic [W-1:0] s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load)
            s_d = SEED;
        else if (run)
            s_d = {s_q[W-2:0], ^(s_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEED;
        else        s_q <= s_d;
    end

    assign bit_o = s_q[W-1];
endmodule

// File: rtl/rng_st_wordbuf.sv
module rng_st_wordbuf #(
    parameter int WW = 128,
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [WW-1:0] din,
    input  logic [IW-1:0] rd_idx,
    output logic [WW-1:0] dout
);
    logic [WW-1:0] ent_q [N];
    logic [WW-1:0] ent_d [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_comb begin
            ent_d[i] = ent_q[i];
            if (clr)
                ent_d[i] = '0;
            else if (push)
                ent_d[i] = (i == N - 1) ? din : ent_q[(i + 1) % N];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    assign dout = ent_q[rd_idx];
endmodule

// File: rtl/rng_st_crc.sv
module rng_st_crc
    import rng_selftest_pkg::*;
#(
    parameter int          WW   = 128,
    parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
    input  logic [31:0]   crc_in,
    input  logic [WW-1:0] word,
    output logic [31:0]   crc_out
);
    always_comb begin
        crc_out = crc_in;
        for (int b = WW - 1; b >= 0; b--)
            crc_out = crc_fold_bit(crc_out, word[b], POLY);
    end
endmodule

// File: rtl/rng_selftest_ctrl.sv
module rng_selftest_ctrl
    import rng_selftest_pkg::*;
#(
    parameter int          WW        = 128,
    parameter int          NWORDS    = 4,
    parameter int          CW        = 16,
    parameter logic [31:0] CRC_POLY  = 32'h04C1_1DB7,
    parameter logic [31:0] CRC_INIT  = 32'hFFFF_FFFF,
    parameter logic [31:0] EXP_CRC   = 32'h0000_0000,
    parameter logic [31:0] LFSR_SEED = 32'h1ACE_B00C,
    parameter logic [31:0] LFSR_TAPS = 32'h8020_0003
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wait_limit,
    input  logic          gen_valid,
    input  logic [WW-1:0] gen_word,
    input  logic          ht_ok,
    output logic          src_sel,
    output logic          lfsr_bit,
    output logic          dn_rst,
    output logic          p1_pass,
    output logic          st_fail,
    output logic          rng_ready
);
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [31:0]   crc;
        logic          pass;
    } ctl_t;

    ctl_t r_d, r_q;
    logic buf_clr, buf_push, lfsr_load;
    logic [WW-1:0] buf_word;
    logic [31:0]   crc_next;
    logic          lim_hit;

    rng_st_lfsr #(.W(32), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(lfsr_load), .run(src_sel), .bit_o(lfsr_bit)
    );

    rng_st_wordbuf #(.WW(WW), .N(NWORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(buf_push),
        .din(gen_word), .rd_idx(r_q.idx), .dout(buf_word)
    );

    rng_st_crc #(.WW(WW), .POLY(CRC_POLY)) u_crc (
        .crc_in(r_q.crc), .word(buf_word), .crc_out(crc_next)
    );

    assign lim_hit = (r_q.cnt == wait_limit - CW'(1));

    always_comb begin
        r_d       = r_q;
        buf_clr   = 1'b0;
        buf_push  = 1'b0;
        lfsr_load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                lfsr_load = 1'b1;
                r_d.cnt   = '0;
                r_d.idx   = '0;
                r_d.st    = ST_COLLECT;
            end
            ST_COLLECT: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (gen_valid) begin
                    buf_push = 1'b1;
                    if (r_q.idx == LAST) begin
                        r_d.idx = '0;
                        r_d.crc = CRC_INIT;
                        r_d.st  = ST_DIGEST;
                    end else begin
                        r_d.idx = r_q.idx + IW'(1);
                    end
                end else if (lim_hit) begin
                    r_d.st = ST_FAIL;
                end
            end
            ST_DIGEST: begin
                r_d.crc = crc_next;
                if (r_q.idx == LAST) r_d.st = ST_COMPARE;
                else                 r_d.idx = r_q.idx + IW'(1);
            end
            ST_COMPARE: begin
                if (r_q.crc == EXP_CRC) begin
                    r_d.pass = 1'b1;
                    r_d.st   = ST_FLUSH;
                end else begin
                    r_d.st = ST_FAIL;
                end
            end
            ST_FLUSH: begin
                buf_clr = 1'b1;
                r_d.cnt = '0;
                r_d.st  = ST_HTWAIT;
            end
            ST_HTWAIT: begin
                if (ht_ok)        r_d.st = ST_READY;
                else if (lim_hit) r_d.st = ST_FAIL;
                else              r_d.cnt = r_q.cnt + CW'(1);
            end
            ST_READY: r_d.st = ST_READY;
            ST_FAIL:  r_d.st = ST_FAIL;
            default:  r_d.st = ST_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.idx  <= '0;
            r_q.crc  <= CRC_INIT;
            r_q.pass <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_sel   = (r_q.st == ST_COLLECT) || (r_q.st == ST_DIGEST) || (r_q.st == ST_COMPARE);
    assign dn_rst    = (r_q.st == ST_FLUSH);
    assign p1_pass   = r_q.pass;
    assign st_fail   = (r_q.st == ST_FAIL);
    assign rng_ready = (r_q.st == ST_READY);
endmodule

// File: rtl/rng_selftest_ctrl_chk.sv
module rng_selftest_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic src_sel,
    input logic dn_rst,
    input logic p1_pass,
    input logic st_fail,
    input logic rng_ready,
    input logic ht_ok
);
    assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_fail |=> st_fail);

    assert_fail_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_fail |-> !rng_ready);

    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rng_ready |=> rng_ready);

    assert_ready_after_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rng_ready |-> p1_pass);

    assert_flush_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rst |=> !dn_rst);

    assert_flush_reconnects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rst |-> (p1_pass && !src_sel));

    assert_flush_to_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rst && ht_ok) |=> 1'b1 ##0 (!st_fail && !src_sel));

    assert_pass_no_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_fail) |-> !dn_rst);
endmodule

bind rng_selftest_ctrl rng_selftest_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dn_rst(dn_rst),
    .p1_pass(p1_pass), .st_fail(st_fail), .rng_ready(rng_ready), .ht_ok(ht_ok)
);

// File: tb/rng_selftest_ctrl_test.sv
module rng_selftest_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SEED = 32'h1ACE_B00C;

    function automatic logic [127:0] word_of(int k);
        return {32'h1357_9BDF ^ 32'(k), 32'h2468_ACE0 + 32'(k),
                32'hDEAD_0000 + 32'(k * 3), 32'h0F0F_F0F0 ^ 32'(k << 4)};
    endfunction

    function automatic logic [31:0] ref_crc4();
        logic [31:0] c;
        logic [127:0] w;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 4; k++) begin
            w = word_of(k);
            for (int b = 127; b >= 0; b--) begin
                fb = c[31] ^ w[b];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    localparam logic [31:0] GOLD = ref_crc4();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] wait_limit = 16'd100;
    logic gen_valid = 1'b0;
    logic [127:0] gen_word = '0;
    logic ht_ok = 1'b0;
    logic src_sel, lfsr_bit, dn_rst, p1_pass, st_fail, rng_ready;

    int n_checks = 0;
    int n_bad = 0;
    int dn_cnt = 0;
    logic exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rng_selftest_ctrl #(.EXP_CRC(GOLD), .LFSR_SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .wait_limit(wait_limit), .gen_valid(gen_valid),
        .gen_word(gen_word), .ht_ok(ht_ok), .src_sel(src_sel), .lfsr_bit(lfsr_bit),
        .dn_rst(dn_rst), .p1_pass(p1_pass), .st_fail(st_fail), .rng_ready(rng_ready)
    );

    task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected LFSR bits (R2) and counts reset pulses (R6)
    always @(negedge clk) begin
        if (rst_n) begin
            if (src_sel && exp_q.size() > 0) begin
                logic e;
                e = exp_q.pop_front();
                check(lfsr_bit == e, "R2 lfsr stream", 128'(lfsr_bit), 128'(e));
            end
            if (dn_rst) dn_cnt++;
        end
    end

    task automatic do_reset(input logic [15:0] lim);
        logic [31:0] s;
        rst_n = 1'b0; gen_valid = 1'b0; ht_ok = 1'b0; wait_limit = lim;
        exp_q.delete();
        s = SEED;
        for (int i = 0; i < 400; i++) begin
            exp_q.push_back(s[31]);
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
        end
        repeat (3) @(negedge clk);
        check({src_sel, dn_rst, p1_pass, st_fail, rng_ready} == 5'b0, "R1 reset outputs",
              128'({src_sel, dn_rst, p1_pass, st_fail, rng_ready}), 128'(0));
        dn_cnt = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(src_sel == 1'b1, "R1 phase one starts", 128'(src_sel), 128'(1));
    endtask

    task automatic send(input logic [127:0] w);
        gen_valid = 1'b1; gen_word = w;
        @(negedge clk);
        gen_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_p1_end();
        for (int i = 0; i < 50 && src_sel; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

    initial begin
        // pass path
        do_reset(16'd100);
        for (int k = 0; k < 4; k++) send(word_of(k));
        wait_p1_end();
        check(p1_pass == 1'b1, "R4 crc match", 128'(p1_pass), 128'(1));
        check(st_fail == 1'b0, "R4 no fail", 128'(st_fail), 128'(0));
        repeat (3) @(negedge clk);
        check(dn_cnt == 1, "R6 single flush", 128'(dn_cnt), 128'(1));
        check(src_sel == 1'b0, "R6 entropy reconnected", 128'(src_sel), 128'(0));
        check(rng_ready == 1'b0, "R7 waits for health", 128'(rng_ready), 128'(0));
        ht_ok = 1'b1;
        repeat (2) @(negedge clk);
        check(rng_ready == 1'b1, "R7 ready", 128'(rng_ready), 128'(1));
        ht_ok = 1'b0;
        send(~word_of(0));
        repeat (3) @(negedge clk);
        check(rng_ready == 1'b1 && st_fail == 1'b0, "R7 ready holds", 128'(rng_ready), 128'(1));

        // swapped order r2,r1 (R3)
        do_reset(16'd100);
        send(word_of(1)); send(word_of(0)); send(word_of(2)); send(word_of(3));
        wait_p1_end();
        @(negedge clk);
        check(st_fail == 1'b1, "R3 order matters", 128'(st_fail), 128'(1));
        check(p1_pass == 1'b0 && dn_cnt == 0, "R5 no pass no flush", 128'({p1_pass, 8'(dn_cnt)}), 128'(0));
        ht_ok = 1'b1;
        repeat (4) @(negedge clk);
        check(rng_ready == 1'b0 && st_fail == 1'b1, "R10 fail sticky", 128'({rng_ready, st_fail}), 128'(1));

        // one flipped bit
        do_reset(16'd100);
        send(word_of(0)); send(word_of(1)); send(word_of(2) ^ 128'd1); send(word_of(3));
        wait_p1_end();
        @(negedge clk);
        check(st_fail == 1'b1 && p1_pass == 1'b0, "R5 bit flip detected", 128'({st_fail, p1_pass}), 128'(2));

        // health timeout exact
        do_reset(16'd12);
        for (int k = 0; k < 4; k++) send(word_of(k));
        for (int i = 0; i < 50 && !dn_rst; i++) @(negedge clk);
        check(dn_rst == 1'b1, "R6 flush seen", 128'(dn_rst), 128'(1));
        repeat (12) @(negedge clk);
        check(st_fail == 1'b0, "R8 no fail at limit", 128'(st_fail), 128'(0));
        @(negedge clk);
        check(st_fail == 1'b1, "R8 fail after limit", 128'(st_fail), 128'(1));
        check(rng_ready == 1'b0, "R8 not ready", 128'(rng_ready), 128'(0));

        // capture timeout
        do_reset(16'd30);
        repeat (40) @(negedge clk);
        check(st_fail == 1'b1 && src_sel == 1'b0, "R9 capture timeout", 128'({st_fail, src_sel}), 128'(2));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end
endmodule